// File: doc/BRIEF.md
# Wait-State Memory Responder with Console Byte Sink

This block answers requests on a 32-bit single-transfer bus that uses a valid/ready handshake. It plays the responder side for a processor model, and it holds a word-organised RAM whose depth is set by a parameter. Once a request is accepted, the block waits a parameterised number of cycles and then raises ready for one cycle. Reads return the full addressed word. Writes change only the byte lanes that the strobe enables. Addresses past the end of the RAM are absorbed: writes there are dropped, reads there return zero, and the handshake still completes.

One fixed word address acts as a console. A write there is not stored. The lowest enabled byte lane goes out on a byte port instead, together with a one-cycle valid pulse, as a stand-in for a serial transmitter. A full-word preload port lets a test environment fill the RAM while the bus is idle.

The sequencer has three named states. `ST_IDLE` waits for a request and leaves through the accept transition. From there it goes to `ST_WAIT`, or straight to `ST_RESP` when the latency parameter is zero. `ST_WAIT` counts down the wait cycles and moves to `ST_RESP` when the count is spent. `ST_RESP` drives ready, commits any write and always returns to `ST_IDLE` through the commit transition.

Top module: `mem_responder`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `bus_ready` and `con_valid` are low and `bus_rdata` is zero.
- R2: If `bus_valid` is sampled high on a rising edge while the block is idle, `bus_ready` is high during the cycle that follows LATENCY further rising edges. Seen from the negative edge after the accepting edge, ready is observed at negative edge number LATENCY+1.
- R3: `bus_ready` is high for exactly one cycle per transfer and is low in the cycle after it.
- R4: A write with a nonzero strobe to an in-range word updates only the enabled byte lanes. Strobe bit 0 selects bits 7:0 and strobe bit 3 selects bits 31:24.
- R5: A request with strobe 4'b0000 is a read. The addressed word appears on `bus_rdata` during the ready cycle, and memory is unchanged.
- R6: A write with a nonzero strobe to any byte of the console word (0x1000_0000 to 0x1000_0003) leaves memory unchanged. During the ready cycle it drives `con_valid` high for one cycle, with `con_byte` equal to the lowest enabled lane of `bus_wdata`.
- R7: A read of the console word returns zero and does not pulse `con_valid`.
- R8: An address whose word index is MEM_WORDS or more completes normally. A write there changes no memory word, and a read there returns zero.
- R9: With LATENCY set to 0, ready is high in the cycle right after the accepting edge.
- R10: `pre_we` writes `pre_word` into word `pre_index` when the block is idle. It is ignored while a transfer is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Request present |
| bus_addr | input | 32 | Byte address of the request |
| bus_wdata | input | 32 | Write data |
| bus_wstrb | input | 4 | Byte-lane enables; zero means read |
| bus_ready | output | 1 | One-cycle completion pulse |
| bus_rdata | output | 32 | Read result, valid while ready is high |
| con_valid | output | 1 | Console byte strobe |
| con_byte | output | 8 | Console byte |
| pre_we | input | 1 | Preload write enable |
| pre_index | input | clog2(MEM_WORDS) | Preload word index |
| pre_word | input | 32 | Preload data |

## Verification
The hardest case to reach from the ports is a preload pulse that arrives while a transfer sits in the wait state. It only shows up if the bench drives the preload port between the accepting edge and the ready pulse, and then reads the targeted word back afterwards. The bench does exactly that in a directed step.

Aliasing is another hazard: an out-of-range write or a console write could land in a low word through a truncated index. To catch it, the bench sends such writes to addresses whose low index bits hit preloaded words, then reads those words back.

Seeded random traffic mixes strobes, in-range, out-of-range and console addresses, and checks every transfer against a bench-side memory model.

// File: rtl/mresp_pkg.sv
package mresp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_RESP
    } mresp_state_e;

    typedef struct packed {
        logic [31:0] addr;
        logic [31:0] wdata;
        logic [3:0]  wstrb;
    } mresp_req_t;

    // Combine an old word with new data under a byte-lane mask.
    function automatic logic [31:0] lane_merge(
        input logic [31:0] old_w,
        input logic [31:0] new_w,
        input logic [3:0]  strb
    );
        logic [31:0] res;
        for (int b = 0; b < 4; b++) begin
            res[8*b +: 8] = strb[b] ? new_w[8*b +: 8] : old_w[8*b +: 8];
        end
        return res;
    endfunction

    // Pick the least significant enabled byte lane.
    function automatic logic [7:0] first_lane(
        input logic [31:0] w,
        input logic [3:0]  strb
    );
        logic [7:0] res;
        res = 8'h00;
        for (int b = 3; b >= 0; b--) begin
            if (strb[b]) res = w[8*b +: 8];
        end
        return res;
    endfunction

endpackage

// File: rtl/mresp_fsm.sv
module mresp_fsm
    import mresp_pkg::*;
#(
    parameter int LATENCY = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         req_valid,
    output mresp_state_e state,
    output logic         accept,
    output logic         commit
);

    localparam int CW = (LATENCY > 1) ? $clog2(LATENCY) : 1;
    localparam logic [CW-1:0] LOADV = CW'((LATENCY > 0) ? LATENCY - 1 : 0);
    localparam int EW = $clog2(LATENCY + 2);

    mresp_state_e state_q, state_d;
    logic [CW-1:0] cnt_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = (LATENCY == 0) ? ST_RESP : ST_WAIT;
            ST_WAIT: if (cnt_q == '0) state_d = ST_RESP;
            ST_RESP: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // wait-cycle down counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            cnt_q <= '0;
        else if (state_q == ST_IDLE && req_valid) cnt_q <= LOADV;
        else if (state_q == ST_WAIT && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    // outputs
    always_comb begin
        state  = state_q;
        accept = (state_q == ST_IDLE) && req_valid;
        commit = (state_q == ST_RESP);
    end

    // Independent up-counter of edges spent waiting, for the latency check.
    logic [EW-1:0] elapsed_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      elapsed_q <= '0;
        else if (accept)                 elapsed_q <= '0;
        else if (state_q == ST_WAIT)     elapsed_q <= elapsed_q + 1'b1;
    end

    p_wait_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RESP) |-> (elapsed_q == EW'(LATENCY)));

endmodule

// File: rtl/mresp_decode.sv
module mresp_decode #(
    parameter int          MEM_WORDS    = 256,
    parameter logic [31:0] CONSOLE_ADDR = 32'h1000_0000,
    localparam int         IDXW         = $clog2(MEM_WORDS)
) (
    input  logic [31:0]     addr,
    output logic            in_range,
    output logic            is_console,
    output logic [IDXW-1:0] idx
);

    logic unused_lane_bits;

    always_comb begin
        in_range         = (addr[31:2] < 30'(MEM_WORDS));
        is_console       = (addr[31:2] == CONSOLE_ADDR[31:2]);
        idx              = addr[IDXW+1:2];
        unused_lane_bits = ^addr[1:0];
    end

endmodule

// File: rtl/mresp_store.sv
module mresp_store
    import mresp_pkg::*;
#(
    parameter int  MEM_WORDS = 256,
    localparam int IDXW      = $clog2(MEM_WORDS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [IDXW-1:0] wr_idx,
    input  logic [31:0]     wr_data,
    input  logic [3:0]      wr_strb,
    input  logic            pre_en,
    input  logic [IDXW-1:0] pre_idx,
    input  logic [31:0]     pre_data,
    input  logic [IDXW-1:0] rd_idx,
    output logic [31:0]     rd_data
);

    logic [31:0] mem [MEM_WORDS];

    always_ff @(posedge clk) begin
        if (wr_en)       mem[wr_idx]  <= lane_merge(mem[wr_idx], wr_data, wr_strb);
        else if (pre_en) mem[pre_idx] <= pre_data;
    end

    assign rd_data = mem[rd_idx];

    // Preload is gated to idle, bus writes happen only when responding.
    p_no_collide_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && pre_en));

endmodule

// File: rtl/mem_responder.sv
module mem_responder
    import mresp_pkg::*;
#(
    parameter int          MEM_WORDS    = 256,
    parameter int          LATENCY      = 2,
    parameter logic [31:0] CONSOLE_ADDR = 32'h1000_0000
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bus_valid,
    input  logic [31:0]                  bus_addr,
    input  logic [31:0]                  bus_wdata,
    input  logic [3:0]                   bus_wstrb,
    output logic                         bus_ready,
    output logic [31:0]                  bus_rdata,
    output logic                         con_valid,
    output logic [7:0]                   con_byte,
    input  logic                         pre_we,
    input  logic [$clog2(MEM_WORDS)-1:0] pre_index,
    input  logic [31:0]                  pre_word
);

    localparam int IDXW = $clog2(MEM_WORDS);

    mresp_state_e    state;
    logic            accept, commit;
    mresp_req_t      req_q;
    logic            in_range, is_console;
    logic [IDXW-1:0] idx;
    logic [31:0]     mem_word;
    logic            is_read, mem_wr, pre_en;

    mresp_fsm #(.LATENCY(LATENCY)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (bus_valid),
        .state     (state),
        .accept    (accept),
        .commit    (commit)
    );

    // capture request on accept
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      req_q <= '0;
        else if (accept) req_q <= '{addr: bus_addr, wdata: bus_wdata, wstrb: bus_wstrb};
    end

    mresp_decode #(.MEM_WORDS(MEM_WORDS), .CONSOLE_ADDR(CONSOLE_ADDR)) u_dec (
        .addr       (req_q.addr),
        .in_range   (in_range),
        .is_console (is_console),
        .idx        (idx)
    );

    always_comb begin
        is_read = (req_q.wstrb == 4'b0000);
        mem_wr  = commit && !is_read && in_range && !is_console;
        pre_en  = pre_we && (state == ST_IDLE);
    end

    mresp_store #(.MEM_WORDS(MEM_WORDS)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (mem_wr),
        .wr_idx   (idx),
        .wr_data  (req_q.wdata),
        .wr_strb  (req_q.wstrb),
        .pre_en   (pre_en),
        .pre_idx  (pre_index),
        .pre_data (pre_word),
        .rd_idx   (idx),
        .rd_data  (mem_word)
    );

    // output process
    always_comb begin
        bus_ready = commit;
        bus_rdata = (commit && is_read && in_range && !is_console) ? mem_word : 32'h0;
        con_valid = commit && is_console && !is_read;
        con_byte  = con_valid ? first_lane(req_q.wdata, req_q.wstrb) : 8'h00;
    end

    p_ready_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready |=> !bus_ready);

    p_read_keeps_mem_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ready && is_read) |=> $stable(mem_word));

    p_console_keeps_mem_r6: assert property (@(posedge clk) disable iff (!rst_n)
        con_valid |=> $stable(mem_word));

endmodule

// File: tb/mem_responder_bench.sv
module mem_responder_bench;

    localparam int          W    = 256;
    localparam int          LAT  = 3;
    localparam logic [31:0] CONS = 32'h1000_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic        valid_a = 0, valid_z = 0;
    logic [31:0] addr = 0, wdata = 0;
    logic [3:0]  wstrb = 0;
    logic        pre_we_a = 0, pre_we_z = 0;
    logic [7:0]  pre_idx = 0;
    logic [31:0] pre_data = 0;
    logic        ready_a, ready_z, cv_a, cv_z;
    logic [31:0] rdata_a, rdata_z;
    logic [7:0]  cb_a, cb_z;

    mem_responder #(.MEM_WORDS(W), .LATENCY(LAT), .CONSOLE_ADDR(CONS)) u_mem_responder (
        .clk(clk), .rst_n(rst_n), .bus_valid(valid_a), .bus_addr(addr),
        .bus_wdata(wdata), .bus_wstrb(wstrb), .bus_ready(ready_a),
        .bus_rdata(rdata_a), .con_valid(cv_a), .con_byte(cb_a),
        .pre_we(pre_we_a), .pre_index(pre_idx), .pre_word(pre_data));

    mem_responder #(.MEM_WORDS(W), .LATENCY(0), .CONSOLE_ADDR(CONS)) u_mem_responder_zero (
        .clk(clk), .rst_n(rst_n), .bus_valid(valid_z), .bus_addr(addr),
        .bus_wdata(wdata), .bus_wstrb(wstrb), .bus_ready(ready_z),
        .bus_rdata(rdata_z), .con_valid(cv_z), .con_byte(cb_z),
        .pre_we(pre_we_z), .pre_index(pre_idx), .pre_word(pre_data));

    logic [31:0] model [W];
    int checks = 0, fails = 0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] seed_word(input int i);
        return (i * 32'h0101_0101) ^ 32'hA5C3_0000;
    endfunction

    function automatic logic [31:0] merge_exp(input logic [31:0] o, input logic [31:0] n, input logic [3:0] s);
        logic [31:0] r;
        r = o;
        if (s[0]) r[7:0]   = n[7:0];
        if (s[1]) r[15:8]  = n[15:8];
        if (s[2]) r[23:16] = n[23:16];
        if (s[3]) r[31:24] = n[31:24];
        return r;
    endfunction

    function automatic logic [7:0] low_byte_exp(input logic [31:0] d, input logic [3:0] s);
        if (s[0]) return d[7:0];
        if (s[1]) return d[15:8];
        if (s[2]) return d[23:16];
        return d[31:24];
    endfunction

    function automatic logic [31:0] read_exp(input logic [31:0] a);
        if (a[31:2] == CONS[31:2]) return 32'h0;
        if (a[31:2] < W)           return model[a[9:2]];
        return 32'h0;
    endfunction

    task automatic xfer(input bit z, input logic [31:0] a, input logic [31:0] d, input logic [3:0] s,
                        output logic [31:0] rd, output int lat, output logic cv, output logic [7:0] cb);
        int n;
        @(negedge clk);
        addr = a; wdata = d; wstrb = s;
        if (z) valid_z = 1'b1; else valid_a = 1'b1;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!(z ? ready_z : ready_a) && n < 40);
        rd = z ? rdata_z : rdata_a;
        cv = z ? cv_z : cv_a;
        cb = z ? cb_z : cb_a;
        lat = n;
        valid_a = 1'b0; valid_z = 1'b0;
        @(negedge clk);
        check((z ? ready_z : ready_a) == 1'b0, "R3 ready single cycle", 32'(z ? ready_z : ready_a), 32'h0);
    endtask

    logic [31:0] rd;
    int          lat;
    logic        cv;
    logic [7:0]  cb;
    bit          finished = 0;

    initial begin
        void'($urandom(32'd2718));
        // R1 during reset
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!ready_a && !cv_a && rdata_a == 0, "R1 reset quiet", {ready_a, cv_a, rdata_a[29:0]}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!ready_a && !cv_a && !ready_z, "R1 after release", {ready_a, cv_a, ready_z}, 32'h0);

        // preload both instances (R10 idle path)
        for (int i = 0; i < W; i++) begin
            @(negedge clk);
            pre_we_a = 1'b1; pre_we_z = 1'b1; pre_idx = 8'(i); pre_data = seed_word(i);
            model[i] = seed_word(i);
        end
        @(negedge clk);
        pre_we_a = 1'b0; pre_we_z = 1'b0;

        // R5 / R2 directed read
        xfer(0, 32'd7 << 2, 32'h0, 4'b0000, rd, lat, cv, cb);
        check(rd == model[7], "R5 read word 7", rd, model[7]);
        check(lat == LAT + 1, "R2 latency", 32'(lat), 32'(LAT + 1));
        check(!cv, "R5 no console on read", 32'(cv), 32'h0);

        // R4 partial write
        xfer(0, 32'd9 << 2, 32'h1122_3344, 4'b0101, rd, lat, cv, cb);
        model[9] = merge_exp(model[9], 32'h1122_3344, 4'b0101);
        xfer(0, 32'd9 << 2, 32'h0, 4'b0000, rd, lat, cv, cb);
        check(rd == model[9], "R4 byte lanes", rd, model[9]);

        // R6 console write, lane 2 lowest enabled
        xfer(0, CONS + 32'd1, 32'h1122_3344, 4'b1100, rd, lat, cv, cb);
        check(cv == 1'b1, "R6 console strobe", 32'(cv), 32'h1);
        check(cb == 8'h22, "R6 console byte", 32'(cb), 32'h22);
        xfer(0, 32'h0, 32'h0, 4'b0000, rd, lat, cv, cb);
        check(rd == model[0], "R6 console not stored", rd, model[0]);

        // R7 console read
        xfer(0, CONS, 32'h0, 4'b0000, rd, lat, cv, cb);
        check(rd == 32'h0 && !cv, "R7 console read zero", rd, 32'h0);

        // R8 out-of-range write aliasing onto word 5, then read back
        xfer(0, 32'(W + 5) << 2, 32'hFFFF_FFFF, 4'b1111, rd, lat, cv, cb);
        check(lat == LAT + 1, "R8 oob completes", 32'(lat), 32'(LAT + 1));
        xfer(0, 32'd5 << 2, 32'h0, 4'b0000, rd, lat, cv, cb);
        check(rd == model[5], "R8 oob write dropped", rd, model[5]);
        xfer(0, 32'(W + 5) << 2, 32'h0, 4'b0000, rd, lat, cv, cb);
        check(rd == 32'h0, "R8 oob read zero", rd, 32'h0);

        // R10 preload during a transfer is ignored
        @(negedge clk);
        addr = 32'd3 << 2; wstrb = 4'b0000; valid_a = 1'b1;
        @(negedge clk);
        pre_we_a = 1'b1; pre_idx = 8'd20; pre_data = 32'hDEAD_BEEF;
        @(negedge clk);
        pre_we_a = 1'b0;
        while (!ready_a) @(negedge clk);
        check(rdata_a == model[3], "R10 read during preload", rdata_a, model[3]);
        valid_a = 1'b0;
        @(negedge clk);
        xfer(0, 32'd20 << 2, 32'h0, 4'b0000, rd, lat, cv, cb);
        check(rd == model[20], "R10 busy preload ignored", rd, model[20]);

        // R9 zero latency instance
        xfer(1, 32'd4 << 2, 32'h0, 4'b0000, rd, lat, cv, cb);
        check(lat == 1, "R9 zero latency", 32'(lat), 32'h1);
        check(rd == seed_word(4), "R9 zero latency data", rd, seed_word(4));
        xfer(1, 32'd50 << 2, 32'hCAFE_F00D, 4'b1010, rd, lat, cv, cb);
        xfer(1, 32'd50 << 2, 32'h0, 4'b0000, rd, lat, cv, cb);
        check(rd == merge_exp(seed_word(50), 32'hCAFE_F00D, 4'b1010), "R9 zero latency write", rd,
              merge_exp(seed_word(50), 32'hCAFE_F00D, 4'b1010));

        // seeded random traffic
        for (int k = 0; k < 400; k++) begin
            int          kind;
            logic [31:0] a, d;
            logic [3:0]  s;
            kind = int'($urandom % 10);
            d    = $urandom;
            s    = ($urandom % 3 == 0) ? 4'b0000 : 4'($urandom);
            if (kind == 0)      a = CONS + 32'($urandom % 4);
            else if (kind == 1) a = 32'(W * 4) + (32'($urandom % 4096) << 2);
            else                a = (32'($urandom % W) << 2) | 32'($urandom % 4);
            xfer(0, a, d, s, rd, lat, cv, cb);
            check(lat == LAT + 1, "R2 random latency", 32'(lat), 32'(LAT + 1));
            if (s == 4'b0000) begin
                check(rd == read_exp(a), "R5 R7 R8 random read", rd, read_exp(a));
                check(!cv, "R7 random no console", 32'(cv), 32'h0);
            end else if (kind == 0) begin
                check(cv && cb == low_byte_exp(d, s), "R6 random console", {23'h0, cv, cb}, {23'h1, low_byte_exp(d, s)});
            end else begin
                check(!cv, "R4 random no console", 32'(cv), 32'h0);
                if (a[31:2] < W) model[a[9:2]] = merge_exp(model[a[9:2]], d, s);
            end
        end

        // final sweep of memory against model
        for (int i = 0; i < W; i += 17) begin
            xfer(0, 32'(i) << 2, 32'h0, 4'b0000, rd, lat, cv, cb);
            check(rd == model[i], "R4 final sweep", rd, model[i]);
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end

endmodule